// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block works out, on its own, what kind of page-organised serial flash sits on a byte-level SPI link and reports the geometry that later access logic needs. The geometry is the number of pages, the bytes per page and the page-address shift, which is the bit position where the page number starts in a flash address. A probe runs once when reset is released, and again each time a new probe is requested after the previous one has finished.

Each probe uses two chip-select frames, with chip select released between them. The first frame sends the identification opcode and collects the manufacturer byte and a two-byte device code. The second frame reads the status byte.

The result is taken from the identification data when the manufacturer byte is the expected one. Status bit 0 then chooses between power-of-two pages and extended pages on parts that offer both. Any other manufacturer byte makes the block fall back to an older density code carried in the status byte. The result stays on the outputs, with a done flag and an outcome code, until the next probe request is accepted.

Top module: `flash_probe_top`

## Requirements
- R1: While reset is held, `spi_cs_o`, `spi_req_o` and `done_o` are low, `outcome_o` is 0 and all geometry outputs are 0. After reset is released, a probe starts with no request.
- R2: The identification frame keeps `spi_cs_o` high across exactly four byte exchanges. The first byte sent is 0x9F. The bytes received on exchanges 2, 3 and 4 are the manufacturer byte, the device code high byte and the device code low byte.
- R3: After the identification frame, `spi_cs_o` stays low for at least GAP_CYCLES cycles (never fewer than 2). Then a status frame of exactly two exchanges is sent: opcode 0xD7, then one byte whose received value is the status byte.
- R4: In a byte exchange, `spi_req_o` stays high and `spi_tx_o` stays stable until `spi_ack_i` is sampled high. A single cycle of `spi_ack_i` completes the byte, and `spi_rx_i` is taken in that cycle. `spi_req_o` is high only while `spi_cs_o` is high.
- R5: `outcome_o` codes are 0 (none yet), 1 (supported), 2 (unsupported) and 3 (no device). For manufacturer 0x1F, the device codes map as follows, each given as pages, extended size and shift: 0x2200 → 512, 264, 9; 0x2300 → 1024, 264, 9; 0x2400 → 2048, 264, 9; 0x2500 → 4096, 264, 9; 0x2600 → 4096, 528, 10; 0x2701 → 8192, 528, 10; 0x2800 → 8192, 1056, 11. For these codes, status bit 0 = 1 selects a size of 2^(shift-1) with the shift reduced by one. Status bit 0 = 0 keeps the extended values.
- R6: Manufacturer 0x1F with device code 0x2700 always gives 8192 pages of 528 bytes with shift 10, whatever status bit 0 holds.
- R7: Manufacturer 0x1F with any device code not listed gives outcome 2, with every geometry output at 0.
- R8: With any manufacturer byte other than 0x1F, a status byte of 0x00 or 0xFF gives outcome 3, with every geometry output at 0.
- R9: With any manufacturer byte other than 0x1F, status bits 5:2 (status AND 0x3C) select the geometry as follows, each given as pages, size and shift: 0x0C → 512, 264, 9; 0x14 → 1024, 264, 9; 0x1C → 2048, 264, 9; 0x24 → 4096, 264, 9; 0x2C → 4096, 528, 10; 0x34 → 8192, 528, 10; 0x38 or 0x3C → 8192, 1056, 11.
- R10: On the fallback path, any other masked value gives outcome 2, with every geometry output at 0.
- R11: After a probe, `done_o` and all result outputs hold steady until `start_i` is sampled high. That sample clears `done_o`, the outcome and the geometry in the next cycle and starts a new probe. `start_i` has no effect while a probe is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new probe once the previous result is shown |
| spi_cs_o | output | 1 | Chip select, high = device selected |
| spi_req_o | output | 1 | Byte exchange request |
| spi_tx_o | output | 8 | Byte to send in the current exchange |
| spi_ack_i | input | 1 | Exchange complete, one cycle |
| spi_rx_i | input | 8 | Byte received, valid with `spi_ack_i` |
| done_o | output | 1 | Probe result valid |
| outcome_o | output | 2 | 0 none, 1 supported, 2 unsupported, 3 no device |
| page_count_o | output | 16 | Number of pages |
| page_size_o | output | 12 | Bytes per page |
| page_shift_o | output | 4 | Page-address shift |

## Verification
A probe request can arrive in the same cycle as the last steps of a running probe. The hardest case is a request in the decode cycle, where the result is being registered, or in the cycle where the status byte completes. To provoke this, the bench holds `start_i` high in every cycle that `done_o` is low, so the request overlaps with each handshake and with the decode step. The bench judges the overlap by counting chip-select frames and their opcodes: exactly two per probe. It also requires a correct, stable result and checks that no further probe begins until a separate request arrives after `done_o` has risen.

// File: rtl/probe_pkg.sv
package probe_pkg;

    localparam int CNT_W   = 16;
    localparam int SIZE_W  = 12;
    localparam int SHIFT_W = 4;

    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_STATUS = 8'hD7;
    localparam logic [7:0] OP_FILL   = 8'h00;
    localparam logic [7:0] MFR_CODE  = 8'h1F;
    localparam logic [7:0] DENS_MASK = 8'h3C;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_OK     = 2'd1,
        OUT_UNSUP  = 2'd2,
        OUT_ABSENT = 2'd3
    } outcome_e;

    typedef enum logic [2:0] {
        PS_BOOT,
        PS_ID_ISSUE,
        PS_ID_WAIT,
        PS_GAP,
        PS_SR_ISSUE,
        PS_SR_WAIT,
        PS_DECODE,
        PS_DONE
    } pstate_e;

    typedef struct packed {
        logic [CNT_W-1:0]   pages;
        logic [SIZE_W-1:0]  size;
        logic [SHIFT_W-1:0] shift;
    } geom_t;

    function automatic geom_t mk_geom(input int p, input int s, input int sh);
        geom_t g;
        g.pages = CNT_W'(p);
        g.size  = SIZE_W'(s);
        g.shift = SHIFT_W'(sh);
        return g;
    endfunction

endpackage

// File: rtl/probe_byte_link.sv
module probe_byte_link
    import probe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    output logic       fin_o,
    output logic [7:0] rx_o,
    output logic       spi_req_o,
    output logic [7:0] spi_tx_o,
    input  logic       spi_ack_i,
    input  logic [7:0] spi_rx_i
);

    typedef struct packed {
        logic       req;
        logic [7:0] tx;
    } link_t;

    link_t q, d;

    always_comb begin
        d = q;
        if (q.req && spi_ack_i) begin
            d.req = 1'b0;
        end else if (go_i && !q.req) begin
            d.req = 1'b1;
            d.tx  = tx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fin_o     = q.req & spi_ack_i;
    assign rx_o      = spi_rx_i;
    assign spi_req_o = q.req;
    assign spi_tx_o  = q.tx;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o))); // R4
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !spi_req_o); // R4

endmodule

// File: rtl/probe_geom_table.sv
module probe_geom_table
    import probe_pkg::*;
(
    input  logic [7:0]  mfr_i,
    input  logic [15:0] dev_i,
    input  logic [7:0]  stat_i,
    output geom_t       geom_o,
    output outcome_e    outcome_o
);

    logic               id_hit;
    logic               bin_capable;
    geom_t              ext_geom;
    geom_t              id_geom;
    geom_t              leg_geom;
    logic               leg_hit;
    logic [7:0]         dens;
    logic [SIZE_W-1:0]  pow2_size;

    // Identification path: extended geometry plus binary-page capability.
    always_comb begin
        id_hit      = 1'b1;
        bin_capable = 1'b1;
        ext_geom    = '0;
        unique case (dev_i)
            16'h2200: ext_geom = mk_geom(512,  264,  9);
            16'h2300: ext_geom = mk_geom(1024, 264,  9);
            16'h2400: ext_geom = mk_geom(2048, 264,  9);
            16'h2500: ext_geom = mk_geom(4096, 264,  9);
            16'h2600: ext_geom = mk_geom(4096, 528,  10);
            16'h2700: begin
                ext_geom    = mk_geom(8192, 528, 10);
                bin_capable = 1'b0;
            end
            16'h2701: ext_geom = mk_geom(8192, 528,  10);
            16'h2800: ext_geom = mk_geom(8192, 1056, 11);
            default: begin
                id_hit      = 1'b0;
                bin_capable = 1'b0;
            end
        endcase
    end

    assign pow2_size = {{(SIZE_W-1){1'b0}}, 1'b1} << (ext_geom.shift - SHIFT_W'(1));

    always_comb begin
        id_geom = ext_geom;
        if (bin_capable && stat_i[0]) begin
            id_geom.size  = pow2_size;
            id_geom.shift = ext_geom.shift - SHIFT_W'(1);
        end
    end

    // Fallback path: density field in the status byte.
    assign dens = stat_i & DENS_MASK;

    always_comb begin
        leg_hit  = 1'b1;
        leg_geom = '0;
        unique case (dens)
            8'h0C:        leg_geom = mk_geom(512,  264,  9);
            8'h14:        leg_geom = mk_geom(1024, 264,  9);
            8'h1C:        leg_geom = mk_geom(2048, 264,  9);
            8'h24:        leg_geom = mk_geom(4096, 264,  9);
            8'h2C:        leg_geom = mk_geom(4096, 528,  10);
            8'h34:        leg_geom = mk_geom(8192, 528,  10);
            8'h38, 8'h3C: leg_geom = mk_geom(8192, 1056, 11);
            default:      leg_hit  = 1'b0;
        endcase
    end

    always_comb begin
        geom_o    = '0;
        outcome_o = OUT_UNSUP;
        if (mfr_i == MFR_CODE) begin
            if (id_hit) begin
                geom_o    = id_geom;
                outcome_o = OUT_OK;
            end
        end else if (stat_i == 8'h00 || stat_i == 8'hFF) begin
            outcome_o = OUT_ABSENT;
        end else if (leg_hit) begin
            geom_o    = leg_geom;
            outcome_o = OUT_OK;
        end
    end

    AST_NOT_OK_ZERO: assert final ((outcome_o == OUT_OK) || (geom_o == '0)); // R7

endmodule

// File: rtl/flash_probe_top.sv
module flash_probe_top
    import probe_pkg::*;
#(
    parameter int GAP_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               spi_cs_o,
    output logic               spi_req_o,
    output logic [7:0]         spi_tx_o,
    input  logic               spi_ack_i,
    input  logic [7:0]         spi_rx_i,
    output logic               done_o,
    output logic [1:0]         outcome_o,
    output logic [CNT_W-1:0]   page_count_o,
    output logic [SIZE_W-1:0]  page_size_o,
    output logic [SHIFT_W-1:0] page_shift_o
);

    localparam int GAP_EFF = (GAP_CYCLES < 2) ? 2 : GAP_CYCLES;
    localparam int GAP_W   = $clog2(GAP_EFF + 1);
    localparam int ID_LAST = 3;
    localparam int SR_LAST = 1;

    typedef struct packed {
        pstate_e          st;
        logic [1:0]       cnt;
        logic [GAP_W-1:0] gap;
        logic [7:0]       mfr;
        logic [15:0]      dev;
        logic [7:0]       stat;
        logic             done;
        outcome_e         outcome;
        geom_t            geom;
    } regs_t;

    regs_t      q, d;
    logic       go;
    logic [7:0] go_tx;
    logic       fin;
    logic [7:0] rx_byte;
    geom_t      tbl_geom;
    outcome_e   tbl_out;

    probe_byte_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .tx_i      (go_tx),
        .fin_o     (fin),
        .rx_o      (rx_byte),
        .spi_req_o (spi_req_o),
        .spi_tx_o  (spi_tx_o),
        .spi_ack_i (spi_ack_i),
        .spi_rx_i  (spi_rx_i)
    );

    probe_geom_table u_table (
        .mfr_i     (q.mfr),
        .dev_i     (q.dev),
        .stat_i    (q.stat),
        .geom_o    (tbl_geom),
        .outcome_o (tbl_out)
    );

    always_comb begin
        d     = q;
        go    = 1'b0;
        go_tx = OP_FILL;
        unique case (q.st)
            PS_BOOT: begin
                d.st  = PS_ID_ISSUE;
                d.cnt = '0;
            end
            PS_ID_ISSUE: begin
                go    = 1'b1;
                go_tx = (q.cnt == 2'd0) ? OP_IDENT : OP_FILL;
                d.st  = PS_ID_WAIT;
            end
            PS_ID_WAIT: begin
                if (fin) begin
                    unique case (q.cnt)
                        2'd1:    d.mfr       = rx_byte;
                        2'd2:    d.dev[15:8] = rx_byte;
                        2'd3:    d.dev[7:0]  = rx_byte;
                        default: ;
                    endcase
                    if (q.cnt == 2'(ID_LAST)) begin
                        d.cnt = '0;
                        d.gap = GAP_W'(GAP_EFF - 1);
                        d.st  = PS_GAP;
                    end else begin
                        d.cnt = q.cnt + 2'd1;
                        d.st  = PS_ID_ISSUE;
                    end
                end
            end
            PS_GAP: begin
                if (q.gap == '0) begin
                    d.st = PS_SR_ISSUE;
                end else begin
                    d.gap = q.gap - GAP_W'(1);
                end
            end
            PS_SR_ISSUE: begin
                go    = 1'b1;
                go_tx = (q.cnt == 2'd0) ? OP_STATUS : OP_FILL;
                d.st  = PS_SR_WAIT;
            end
            PS_SR_WAIT: begin
                if (fin) begin
                    if (q.cnt == 2'(SR_LAST)) begin
                        d.stat = rx_byte;
                        d.cnt  = '0;
                        d.st   = PS_DECODE;
                    end else begin
                        d.cnt = q.cnt + 2'd1;
                        d.st  = PS_SR_ISSUE;
                    end
                end
            end
            PS_DECODE: begin
                d.outcome = tbl_out;
                d.geom    = (tbl_out == OUT_OK) ? tbl_geom : '0;
                d.done    = 1'b1;
                d.st      = PS_DONE;
            end
            PS_DONE: begin
                if (start_i) begin
                    d.done    = 1'b0;
                    d.outcome = OUT_NONE;
                    d.geom    = '0;
                    d.cnt     = '0;
                    d.st      = PS_ID_ISSUE;
                end
            end
            default: d.st = PS_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PS_BOOT;
        end else begin
            q <= d;
        end
    end

    assign spi_cs_o     = (q.st == PS_ID_ISSUE) || (q.st == PS_ID_WAIT) ||
                          (q.st == PS_SR_ISSUE) || (q.st == PS_SR_WAIT);
    assign done_o       = q.done;
    assign outcome_o    = q.outcome;
    assign page_count_o = q.geom.pages;
    assign page_size_o  = q.geom.size;
    assign page_shift_o = q.geom.shift;

    AST_REQ_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_o |-> spi_cs_o); // R4
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_o) |=> !spi_cs_o); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(outcome_o) && $stable(page_count_o)
                                  && $stable(page_size_o) && $stable(page_shift_o))); // R11
    AST_DONE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !spi_cs_o); // R11
    AST_OK_GEOM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && outcome_o == OUT_OK) |-> (page_count_o != '0 && page_size_o != '0)); // R5
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && outcome_o != OUT_OK) |-> (page_count_o == '0 && page_size_o == '0
                                             && page_shift_o == '0)); // R7
    AST_NO_RESULT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (outcome_o == OUT_NONE)); // R11

endmodule

// File: tb/tb_flash_probe_top.sv
module tb_flash_probe_top;

    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        spi_cs, spi_req, spi_ack;
    logic [7:0]  spi_tx, spi_rx;
    logic        done;
    logic [1:0]  outcome;
    logic [15:0] pages;
    logic [11:0] psize;
    logic [3:0]  pshift;

    always #5 clk = ~clk;

    flash_probe_top #(.GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .spi_cs_o(spi_cs), .spi_req_o(spi_req), .spi_tx_o(spi_tx),
        .spi_ack_i(spi_ack), .spi_rx_i(spi_rx),
        .done_o(done), .outcome_o(outcome), .page_count_o(pages),
        .page_size_o(psize), .page_shift_o(pshift)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Attached device model
    logic [7:0] m_mfr, m_hi, m_lo, m_stat;
    logic [7:0] cur_op;
    int         idx = 0;
    int         frames = 0;
    logic [7:0] fop [0:7];
    int         fbytes [0:7];
    int         low_run = 0;
    int         min_gap = 1000;
    logic       cs_prev = 1'b0;
    logic       pend = 1'b0;
    logic [7:0] pend_tx = 8'h00;
    int         tx_viol = 0;

    function automatic logic [7:0] respond(input int i, input logic [7:0] op);
        logic [7:0] r;
        r = 8'h00;
        if (op == 8'h9F) begin
            if (i == 1) r = m_mfr;
            else if (i == 2) r = m_hi;
            else if (i == 3) r = m_lo;
        end else if (op == 8'hD7 && i >= 1) begin
            r = m_stat;
        end
        return r;
    endfunction

    initial begin
        spi_ack = 1'b0;
        spi_rx  = 8'h00;
        forever begin
            @(negedge clk);
            if (spi_cs && !cs_prev) begin
                if (frames > 0 && low_run < min_gap) min_gap = low_run;
                frames = frames + 1;
                idx = 0;
            end
            if (!spi_cs) low_run = low_run + 1;
            else low_run = 0;
            cs_prev = spi_cs;
            if (spi_ack) begin
                spi_ack = 1'b0;
            end else if (spi_req) begin
                if (pend && spi_tx != pend_tx) tx_viol = tx_viol + 1;
                pend = 1'b1;
                pend_tx = spi_tx;
                if ($urandom_range(0, 2) == 0) begin
                    if (idx == 0) cur_op = spi_tx;
                    spi_rx  = respond(idx, cur_op);
                    spi_ack = 1'b1;
                    pend    = 1'b0;
                    if (frames >= 1 && frames <= 8) begin
                        if (idx == 0) fop[frames-1] = spi_tx;
                        fbytes[frames-1] = idx + 1;
                    end
                    idx = idx + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void expect_res(input logic [7:0] mf, input logic [7:0] hi,
                                       input logic [7:0] lo, input logic [7:0] st,
                                       output int out, output int pg, output int sz,
                                       output int sh);
        int ep, es, esh, ps;
        logic [15:0] dv;
        logic [7:0]  dn;
        ep = 0; es = 0; esh = 0; ps = 0;
        out = 2; pg = 0; sz = 0; sh = 0;
        dv = {hi, lo};
        dn = st & 8'h3C;
        if (mf == 8'h1F) begin
            case (dv)
                16'h2200: begin ep = 512;  es = 264;  esh = 9;  ps = 256;  end
                16'h2300: begin ep = 1024; es = 264;  esh = 9;  ps = 256;  end
                16'h2400: begin ep = 2048; es = 264;  esh = 9;  ps = 256;  end
                16'h2500: begin ep = 4096; es = 264;  esh = 9;  ps = 256;  end
                16'h2600: begin ep = 4096; es = 528;  esh = 10; ps = 512;  end
                16'h2700: begin ep = 8192; es = 528;  esh = 10; ps = 0;    end
                16'h2701: begin ep = 8192; es = 528;  esh = 10; ps = 512;  end
                16'h2800: begin ep = 8192; es = 1056; esh = 11; ps = 1024; end
                default: ;
            endcase
            if (ep != 0) begin
                out = 1; pg = ep;
                if (ps != 0 && st[0]) begin sz = ps; sh = esh - 1; end
                else begin sz = es; sh = esh; end
            end
        end else if (st == 8'h00 || st == 8'hFF) begin
            out = 3;
        end else begin
            out = 1;
            case (dn)
                8'h0C: begin pg = 512;  sz = 264;  sh = 9;  end
                8'h14: begin pg = 1024; sz = 264;  sh = 9;  end
                8'h1C: begin pg = 2048; sz = 264;  sh = 9;  end
                8'h24: begin pg = 4096; sz = 264;  sh = 9;  end
                8'h2C: begin pg = 4096; sz = 528;  sh = 10; end
                8'h34: begin pg = 8192; sz = 528;  sh = 10; end
                8'h38, 8'h3C: begin pg = 8192; sz = 1056; sh = 11; end
                default: out = 2;
            endcase
        end
    endfunction

    function automatic string tag_for(input logic [7:0] mf, input logic [7:0] hi,
                                      input logic [7:0] lo, input logic [7:0] st, input int out);
        if (mf == 8'h1F) begin
            if (out == 2) return "R7";
            if ({hi, lo} == 16'h2700) return "R6";
            return "R5";
        end
        if (out == 3) return "R8";
        if (out == 2) return "R10";
        return "R9";
    endfunction

    // Runs one probe; first=1 uses the probe started by reset release.
    task automatic run_probe(input logic [7:0] mf, input logic [7:0] hi,
                             input logic [7:0] lo, input logic [7:0] st,
                             input bit first, input bit spam);
        int eo, ep, es, esh;
        string t;
        bit seen;
        m_mfr = mf; m_hi = hi; m_lo = lo; m_stat = st;
        if (!first) begin
            frames = 0; min_gap = 1000;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done == 1'b0, "R11", "done cleared after request", done, 0);
            check(outcome == 2'd0, "R11", "outcome cleared after request", outcome, 0);
        end
        seen = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
            start = spam;
        end
        start = 1'b0;
        check(seen, "R11", "probe completes", seen, 1);
        expect_res(mf, hi, lo, st, eo, ep, es, esh);
        t = tag_for(mf, hi, lo, st, eo);
        check(outcome == eo, t, "outcome", outcome, eo);
        check(pages == ep, t, "page count", pages, ep);
        check(psize == es, t, "page size", psize, es);
        check(pshift == esh, t, "page shift", pshift, esh);
        check(frames == 2, "R11", "frames per probe", frames, 2);
        check(fop[0] == 8'h9F && fbytes[0] == 4, "R2", "id frame opcode/bytes",
              fop[0] * 16 + fbytes[0], 8'h9F * 16 + 4);
        check(fop[1] == 8'hD7 && fbytes[1] == 2, "R3", "status frame opcode/bytes",
              fop[1] * 16 + fbytes[1], 8'hD7 * 16 + 2);
        check(min_gap >= GAP, "R3", "cs gap cycles", min_gap, GAP);
        repeat (6) @(negedge clk);
        check(done && outcome == eo && pages == ep && psize == es && pshift == esh,
              "R11", "result held", pages, ep);
        check(frames == 2, "R11", "no extra frame while idle", frames, 2);
    endtask

    initial begin
        int rc;
        rst_n = 1'b0;
        start = 1'b0;
        m_mfr = 8'h1F; m_hi = 8'h26; m_lo = 8'h00; m_stat = 8'h81;
        repeat (5) @(negedge clk);
        check(!spi_cs && !spi_req && !done, "R1", "idle controls in reset",
              {spi_cs, spi_req, done}, 0);
        check(outcome == 0 && pages == 0 && psize == 0 && pshift == 0, "R1",
              "results zero in reset", pages, 0);
        frames = 0; min_gap = 1000;
        rst_n = 1'b1;
        run_probe(8'h1F, 8'h26, 8'h00, 8'h81, 1'b1, 1'b0); // R1 auto probe, R5
        run_probe(8'h1F, 8'h22, 8'h00, 8'h00, 1'b0, 1'b0); // R5 status zero on id path
        run_probe(8'h1F, 8'h28, 8'h00, 8'hFF, 1'b0, 1'b1); // R5 + overlap of start
        run_probe(8'h1F, 8'h27, 8'h00, 8'h01, 1'b0, 1'b0); // R6
        run_probe(8'h1F, 8'h27, 8'h01, 8'h01, 1'b0, 1'b1); // R5
        run_probe(8'h1F, 8'h99, 8'h00, 8'h01, 1'b0, 1'b0); // R7
        run_probe(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0); // R8
        run_probe(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1); // R8 masked 0x3C ignored
        run_probe(8'h00, 8'h00, 8'h00, 8'h8C, 1'b0, 1'b0); // R9
        run_probe(8'h00, 8'h00, 8'h00, 8'hB8, 1'b0, 1'b0); // R9 0x38
        run_probe(8'h00, 8'h00, 8'h00, 8'hBC, 1'b0, 1'b1); // R9 0x3C
        run_probe(8'h00, 8'h00, 8'h00, 8'h90, 1'b0, 1'b0); // R10
        run_probe(8'h00, 8'h00, 8'h00, 8'hB7, 1'b0, 1'b0); // R9
        void'($urandom(32'h5eed));
        for (int n = 0; n < 40; n++) begin
            logic [7:0] mf, hi, lo, st;
            mf = ($urandom_range(0, 1) == 0) ? 8'h1F : 8'($urandom);
            rc = $urandom_range(0, 9);
            if (rc < 8) begin
                hi = 8'h22 + 8'(rc < 6 ? rc : 6);
                lo = (rc == 6) ? 8'h01 : 8'h00;
                if (rc == 7) begin hi = 8'h27; lo = 8'h00; end
            end else begin
                hi = 8'($urandom); lo = 8'($urandom);
            end
            st = 8'($urandom);
            run_probe(mf, hi, lo, st, 1'b0, ($urandom_range(0, 1) == 1));
        end
        check(tx_viol == 0, "R4", "tx stable while request pending", tx_viol, 0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule